// File: doc/BRIEF.md
# Exception Priority Controller

This block sits beside the retire stage of an in-order core and decides, once per cycle, whether an exception is taken and which one. It takes six asynchronous request lines (hard reset, machine check, soft reset, system management interrupt, external interrupt and decrementer). It also takes the synchronous fault flags of the oldest instruction, the faults reported by the fetch stage, and four machine-state enable bits. Alongside these it receives a completion status, a pipeline-empty flag and a recoverable-state indicator. Requests that cannot be served at once are held as pending until their own take rule is met.

Each class has its own take rule. A hard reset is taken at once. A machine check is also taken at once, or it stops the machine when checking is disabled. A soft reset waits for a recoverable state. Faults of the oldest instruction are taken in place of its completion. A trace is taken after a clean completion. Fetch faults hold dispatch and wait for the pipeline to drain. The masked interrupts wait for a completion window. The winner is shown for one cycle as a 5-bit cause index together with its handler offset.

Top module: `exc_arbiter`

## Requirements
- R1: Outputs are registered: a decision made from the inputs and pending state of one cycle appears after the next rising edge. In any cycle with take_o low, cause_o, vec_o and suppress_o read zero, and they also read zero after reset.
- R2: A hard reset request wins over everything and gives cause 0 with offset 0x00100. The same edge clears every pending request and the stopped state.
- R3: A machine check with msr_me_i=1 is taken at once, regardless of recov_i, and gives cause 1 with offset 0x00200. With msr_me_i=0 it sets checkstop_o instead. While checkstop_o is high, no exception other than a hard reset is taken.
- R4: A soft reset stays pending until recov_i=1. It is then taken as cause 2 with offset 0x00100.
- R5: The system management (cause 3, 0x01400), external (cause 4, 0x00500) and decrementer (cause 5, 0x00900) requests are taken only under three conditions together: msr_ee_i=1, recov_i=1, and either a fault-free, trace-free completion of the oldest instruction or an empty pipeline with no oldest instruction. They are taken one per cycle in that order.
- R6: When the oldest instruction faults while a masked interrupt is pending, the fault is taken and the interrupt stays pending.
- R7: head_flt_i bits are ranked with bit 0 highest. Bit 0 gives cause 8 (0x01300). Bit 1 and bit 4 give cause 9 (0x00700). Bit 2 gives cause 10 (0x00C00). Bit 3 gives cause 11 (0x00800). Bits 5 and 9 give cause 12 (0x00600). Bits 6, 7 and 10 give cause 13 (0x00300). A fault take raises suppress_o.
- R8: Bit 8 gives cause 14 (0x01100) for a load and cause 15 (0x01200) when head_store_i=1. Bit 11 always gives cause 15.
- R9: A trace (cause 16, 0x00D00, suppress_o low) is taken when the oldest instruction completes without a fault and either msr_se_i=1 or both msr_be_i=1 and head_branch_i=1. A fault of that instruction takes its place.
- R10: A fetch fault raises dispatch_hold_o from the next cycle on. It is taken once there is no oldest instruction, pipe_empty_i=1 and recov_i=1: a translation miss (fetch_tlb_i) gives cause 6 (0x01000) and is ranked above an access fault (fetch_acc_i), which gives cause 7 (0x00400). A fault or trace taken for an older instruction discards the fetch fault.
- R11: Classes rank as follows, highest first: hard reset, machine check, soft reset, instruction fault, trace, fetch fault, masked interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hreset_req_i | input | 1 | Hard or power-on reset request pulse |
| mchk_req_i | input | 1 | Machine check request pulse |
| sreset_req_i | input | 1 | Soft reset request pulse |
| smi_req_i | input | 1 | System management interrupt request pulse |
| ext_req_i | input | 1 | External interrupt request pulse |
| dec_req_i | input | 1 | Decrementer event pulse |
| msr_ee_i | input | 1 | Masked-interrupt enable |
| msr_me_i | input | 1 | Machine check enable |
| msr_se_i | input | 1 | Single-step trace enable |
| msr_be_i | input | 1 | Branch trace enable |
| recov_i | input | 1 | Machine is in a recoverable state |
| pipe_empty_i | input | 1 | No instruction in flight |
| head_valid_i | input | 1 | Oldest instruction is presented this cycle |
| head_done_i | input | 1 | Oldest instruction completes this cycle |
| head_branch_i | input | 1 | Oldest instruction is a branch |
| head_store_i | input | 1 | Oldest instruction is a store |
| head_flt_i | input | 12 | Fault flags of the oldest instruction, bit 0 highest |
| fetch_tlb_i | input | 1 | Fetch translation miss pulse |
| fetch_acc_i | input | 1 | Fetch access fault pulse |
| take_o | output | 1 | Exception taken this cycle |
| cause_o | output | 5 | Cause index |
| vec_o | output | 20 | Handler offset |
| suppress_o | output | 1 | Faulting instruction must not complete |
| checkstop_o | output | 1 | Machine stopped after a disabled machine check |
| dispatch_hold_o | output | 1 | Dispatch held for a pending fetch fault |

## Verification
Every result is due exactly one rising edge after the cycle in which its inputs are driven. take_o, cause_o, vec_o, suppress_o and checkstop_o, together with dispatch_hold_o for a fetch fault, all change on that edge. The bench therefore drives a cycle's inputs just after an edge, advances one edge, and reads all six outputs 1 ns later. It then changes the inputs for the next cycle. Its model of the pending, fetch and stopped state is advanced once per cycle, so pending effects, such as an interrupt deferred behind a fault, are compared on the cycle they become due.

// File: rtl/exc_pkg.sv
// Shared constants for the exception priority controller: cause indices,
// fault-flag positions and the cause-to-offset mapping.
// Assumes a 5-bit cause index and a 20-bit handler offset.
package exc_pkg;
    localparam int NCAUSE = 17;
    localparam int CW     = $clog2(NCAUSE);
    localparam int NSF    = 12;
    localparam int NASYNC = 6;
    localparam int NFETCH = 2;

    // cause indices; the asynchronous ones follow their rank order
    localparam int C_HRES  = 0;
    localparam int C_MCHK  = 1;
    localparam int C_SRES  = 2;
    localparam int C_SMI   = 3;
    localparam int C_EXT   = 4;
    localparam int C_DEC   = 5;
    localparam int C_ITLB  = 6;
    localparam int C_ISI   = 7;
    localparam int C_IABR  = 8;
    localparam int C_PROG  = 9;
    localparam int C_SC    = 10;
    localparam int C_FPU   = 11;
    localparam int C_ALIGN = 12;
    localparam int C_DSI   = 13;
    localparam int C_DTLBL = 14;
    localparam int C_DTLBS = 15;
    localparam int C_TRACE = 16;

    // Handler offset for each cause index.
    function automatic logic [19:0] vec_of(input logic [CW-1:0] c);
        case (c)
            5'd0:    return 20'h00100;
            5'd1:    return 20'h00200;
            5'd2:    return 20'h00100;
            5'd3:    return 20'h01400;
            5'd4:    return 20'h00500;
            5'd5:    return 20'h00900;
            5'd6:    return 20'h01000;
            5'd7:    return 20'h00400;
            5'd8:    return 20'h01300;
            5'd9:    return 20'h00700;
            5'd10:   return 20'h00C00;
            5'd11:   return 20'h00800;
            5'd12:   return 20'h00600;
            5'd13:   return 20'h00300;
            5'd14:   return 20'h01100;
            5'd15:   return 20'h01200;
            5'd16:   return 20'h00D00;
            default: return 20'h00000;
        endcase
    endfunction

    // Cause for the winning fault-flag position of the oldest instruction.
    function automatic int flt_cause(input int b, input logic st);
        case (b)
            0:       return C_IABR;
            1, 4:    return C_PROG;
            2:       return C_SC;
            3:       return C_FPU;
            5, 9:    return C_ALIGN;
            8:       return st ? C_DTLBS : C_DTLBL;
            11:      return C_DTLBS;
            default: return C_DSI;
        endcase
    endfunction
endpackage

// File: rtl/exc_pend_reg.sv
// Sticky pending-request register. A bit is set by its request pulse and
// cleared when the arbiter takes it; a flush clears all bits.
// Assumes set and clear of one bit in the same cycle means "taken".
module exc_pend_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         flush_i,
    output logic [N-1:0] q_o
);
    // holds each request until taken or flushed
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) q_o <= '0;
        else                   q_o <= (q_o | set_i) & ~clr_i;
    end
endmodule

// File: rtl/exc_sync_pick.sv
// Ranks the fault flags of the oldest instruction (bit 0 highest) and
// returns the cause index of the winner. Purely combinational.
module exc_sync_pick
    import exc_pkg::*;
(
    input  logic [NSF-1:0] flt_i,
    input  logic           store_i,
    output logic           hit_o,
    output logic [CW-1:0]  cause_o
);
    // lowest set flag position wins
    always_comb begin
        int first;
        first = 0;
        for (int i = NSF - 1; i >= 0; i--) begin
            if (flt_i[i]) first = i;
        end
        hit_o   = |flt_i;
        cause_o = CW'(flt_cause(first, store_i));
    end
endmodule

// File: rtl/exc_encode.sv
// Converts a one-hot winner vector into a cause index and handler offset.
// Assumes at most one bit of the input is set.
module exc_encode
    import exc_pkg::*;
#(
    parameter int N     = NCAUSE,
    parameter int VEC_W = 20,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]     oh_i,
    output logic [IW-1:0]    idx_o,
    output logic [VEC_W-1:0] vec_o
);
    logic [IW-1:0] term [N];

    for (genvar g = 0; g < N; g++) begin : g_term
        assign term[g] = oh_i[g] ? IW'(g) : '0;
    end

    // OR-reduces the per-bit index terms
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) idx_o = idx_o | term[i];
    end

    // maps the index to its offset, zero when nothing wins
    always_comb begin
        vec_o = (|oh_i) ? VEC_W'(vec_of(CW'(idx_o))) : '0;
    end
endmodule

// File: rtl/exc_arbiter.sv
// Exception priority controller. Each cycle it picks at most one exception
// from hard reset, machine check, soft reset, oldest-instruction faults,
// trace, fetch faults and masked interrupts, applying each class's take rule,
// and registers the winner. Assumes request inputs are single-cycle pulses
// and that the head inputs describe one retire attempt per cycle.
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int VEC_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hreset_req_i,
    input  logic             mchk_req_i,
    input  logic             sreset_req_i,
    input  logic             smi_req_i,
    input  logic             ext_req_i,
    input  logic             dec_req_i,
    input  logic             msr_ee_i,
    input  logic             msr_me_i,
    input  logic             msr_se_i,
    input  logic             msr_be_i,
    input  logic             recov_i,
    input  logic             pipe_empty_i,
    input  logic             head_valid_i,
    input  logic             head_done_i,
    input  logic             head_branch_i,
    input  logic             head_store_i,
    input  logic [11:0]      head_flt_i,
    input  logic             fetch_tlb_i,
    input  logic             fetch_acc_i,
    output logic             take_o,
    output logic [4:0]       cause_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             suppress_o,
    output logic             checkstop_o,
    output logic             dispatch_hold_o
);
    logic [NASYNC-1:0] a_req, a_pend, a_eff, a_clr;
    logic [NFETCH-1:0] f_req, f_pend, f_eff, f_clr;
    logic [NCAUSE-1:0] win_oh;
    logic              flush, stop_set, supp;
    logic              s_hit;
    logic [CW-1:0]     s_cause, w_idx;
    logic [VEC_W-1:0]  w_vec;
    logic              trace_ok, win_mask;

    assign a_req = {dec_req_i, ext_req_i, smi_req_i,
                    sreset_req_i, mchk_req_i, hreset_req_i};
    assign f_req = {fetch_acc_i, fetch_tlb_i};
    assign a_eff = a_pend | a_req;
    assign f_eff = f_pend | f_req;

    exc_pend_reg #(.N(NASYNC)) u_apend (
        .clk(clk), .rst_n(rst_n), .set_i(a_req), .clr_i(a_clr),
        .flush_i(flush), .q_o(a_pend)
    );

    exc_pend_reg #(.N(NFETCH)) u_fpend (
        .clk(clk), .rst_n(rst_n), .set_i(f_req), .clr_i(f_clr),
        .flush_i(flush), .q_o(f_pend)
    );

    exc_sync_pick u_pick (
        .flt_i(head_flt_i), .store_i(head_store_i),
        .hit_o(s_hit), .cause_o(s_cause)
    );

    exc_encode #(.N(NCAUSE), .VEC_W(VEC_W)) u_enc (
        .oh_i(win_oh), .idx_o(w_idx), .vec_o(w_vec)
    );

    assign trace_ok = head_valid_i && head_done_i &&
                      (msr_se_i || (msr_be_i && head_branch_i));
    assign win_mask = msr_ee_i && recov_i &&
                      ((head_valid_i && head_done_i) ||
                       (!head_valid_i && pipe_empty_i));

    // ranks the classes and applies each take rule
    always_comb begin
        win_oh   = '0;
        a_clr    = '0;
        f_clr    = '0;
        flush    = 1'b0;
        stop_set = 1'b0;
        supp     = 1'b0;
        if (a_eff[C_HRES]) begin
            win_oh[C_HRES] = 1'b1;
            flush          = 1'b1;
        end else if (checkstop_o) begin
            win_oh = '0;
        end else if (a_eff[C_MCHK]) begin
            a_clr[C_MCHK] = 1'b1;
            if (msr_me_i) win_oh[C_MCHK] = 1'b1;
            else          stop_set       = 1'b1;
        end else if (a_eff[C_SRES] && recov_i) begin
            win_oh[C_SRES] = 1'b1;
            a_clr[C_SRES]  = 1'b1;
        end else if (head_valid_i && s_hit) begin
            win_oh[s_cause] = 1'b1;
            supp            = 1'b1;
            f_clr           = '1;
        end else if (trace_ok) begin
            win_oh[C_TRACE] = 1'b1;
            f_clr           = '1;
        end else if (!head_valid_i && pipe_empty_i && recov_i && (|f_eff)) begin
            if (f_eff[0]) begin
                win_oh[C_ITLB] = 1'b1;
                f_clr[0]       = 1'b1;
            end else begin
                win_oh[C_ISI]  = 1'b1;
                f_clr[1]       = 1'b1;
            end
        end else if (win_mask) begin
            if (a_eff[C_SMI]) begin
                win_oh[C_SMI] = 1'b1;
                a_clr[C_SMI]  = 1'b1;
            end else if (a_eff[C_EXT]) begin
                win_oh[C_EXT] = 1'b1;
                a_clr[C_EXT]  = 1'b1;
            end else if (a_eff[C_DEC]) begin
                win_oh[C_DEC] = 1'b1;
                a_clr[C_DEC]  = 1'b1;
            end
        end
    end

    // registers the winner for a one-cycle take strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o     <= 1'b0;
            cause_o    <= '0;
            vec_o      <= '0;
            suppress_o <= 1'b0;
        end else begin
            take_o     <= |win_oh;
            cause_o    <= w_idx;
            vec_o      <= w_vec;
            suppress_o <= supp;
        end
    end

    // sticky stopped state, left only through a hard reset
    always_ff @(posedge clk) begin
        if (!rst_n || flush) checkstop_o <= 1'b0;
        else if (stop_set)   checkstop_o <= 1'b1;
    end

    assign dispatch_hold_o = |f_pend;
endmodule

// File: rtl/exc_arbiter_chk.sv
// Property checker for exc_arbiter, attached through bind below.
// Assumes the same cause index numbering as the block's requirements.
module exc_arbiter_chk #(
    parameter int VEC_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hreset_req_i,
    input logic             msr_ee_i,
    input logic             recov_i,
    input logic             head_valid_i,
    input logic             pipe_empty_i,
    input logic             take_o,
    input logic [4:0]       cause_o,
    input logic [VEC_W-1:0] vec_o,
    input logic             suppress_o,
    input logic             checkstop_o
);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (cause_o == 5'd0 && vec_o == '0 && !suppress_o));

    assert_hres_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hreset_req_i |=> (take_o && cause_o == 5'd0 && !checkstop_o));

    assert_cstop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop_o |-> !take_o);

    assert_sres_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cause_o == 5'd2) |-> $past(recov_i));

    assert_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && cause_o >= 5'd3 && cause_o <= 5'd5) |->
            ($past(msr_ee_i) && $past(recov_i)));

    assert_supp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        suppress_o |-> (take_o && cause_o >= 5'd8 && cause_o <= 5'd15));

    assert_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && (cause_o == 5'd6 || cause_o == 5'd7)) |->
            $past(!head_valid_i && pipe_empty_i && recov_i));
endmodule

bind exc_arbiter exc_arbiter_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/sim_exc_arbiter.sv
module sim_exc_arbiter;
    logic clk = 1'b0;
    logic rst_n;
    logic hres, mchk, sres, smi, ext, dec;
    logic ee, me, se, be, recov, empty;
    logic hv, hd, hbr, hst;
    logic [11:0] flt;
    logic ftlb, facc;
    logic take;
    logic [4:0] cause;
    logic [19:0] vec;
    logic supp, cstop, hold;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [5:0] ma;
    logic [1:0] mf;
    logic mc;

    always #5 clk = ~clk;

    exc_arbiter u0 (
        .clk(clk), .rst_n(rst_n),
        .hreset_req_i(hres), .mchk_req_i(mchk), .sreset_req_i(sres),
        .smi_req_i(smi), .ext_req_i(ext), .dec_req_i(dec),
        .msr_ee_i(ee), .msr_me_i(me), .msr_se_i(se), .msr_be_i(be),
        .recov_i(recov), .pipe_empty_i(empty),
        .head_valid_i(hv), .head_done_i(hd), .head_branch_i(hbr),
        .head_store_i(hst), .head_flt_i(flt),
        .fetch_tlb_i(ftlb), .fetch_acc_i(facc),
        .take_o(take), .cause_o(cause), .vec_o(vec),
        .suppress_o(supp), .checkstop_o(cstop), .dispatch_hold_o(hold)
    );

    function automatic logic [19:0] exp_vec(input int c);
        case (c)
            0, 2: return 20'h00100;
            1:    return 20'h00200;
            3:    return 20'h01400;
            4:    return 20'h00500;
            5:    return 20'h00900;
            6:    return 20'h01000;
            7:    return 20'h00400;
            8:    return 20'h01300;
            9:    return 20'h00700;
            10:   return 20'h00C00;
            11:   return 20'h00800;
            12:   return 20'h00600;
            13:   return 20'h00300;
            14:   return 20'h01100;
            15:   return 20'h01200;
            16:   return 20'h00D00;
            default: return 20'h0;
        endcase
    endfunction

    function automatic int flt_to_cause(input logic [11:0] f, input logic st);
        for (int i = 0; i < 12; i++) begin
            if (f[i]) begin
                case (i)
                    0: return 8;
                    1, 4: return 9;
                    2: return 10;
                    3: return 11;
                    5, 9: return 12;
                    8: return st ? 15 : 14;
                    11: return 15;
                    default: return 13;
                endcase
            end
        end
        return -1;
    endfunction

    function automatic string req_of(input int c);
        if (c < 0)  return "R1";
        if (c == 0) return "R2";
        if (c == 1) return "R3";
        if (c == 2) return "R4";
        if (c <= 5) return "R5";
        if (c <= 7) return "R10";
        if (c == 14 || c == 15) return "R8";
        if (c == 16) return "R9";
        return "R7";
    endfunction

    task automatic clr_in();
        hres = 0; mchk = 0; sres = 0; smi = 0; ext = 0; dec = 0;
        hv = 0; hd = 0; hbr = 0; hst = 0; flt = '0; ftlb = 0; facc = 0;
    endtask

    // one cycle: predict from the requirements, advance one edge, compare
    task automatic run_cycle(input string tag);
        logic [5:0] ae, ca;
        logic [1:0] fe, cf;
        int ec;
        logic es, fl, st;
        ae = ma | {dec, ext, smi, sres, mchk, hres};
        fe = mf | {facc, ftlb};
        ec = -1; es = 0; ca = '0; cf = '0; fl = 0; st = 0;
        if (ae[0]) begin ec = 0; fl = 1; end
        else if (mc) ec = -1;
        else if (ae[1]) begin ca[1] = 1; if (me) ec = 1; else st = 1; end
        else if (ae[2] && recov) begin ec = 2; ca[2] = 1; end
        else if (hv && |flt) begin ec = flt_to_cause(flt, hst); es = 1; cf = 2'b11; end
        else if (hv && hd && (se || (be && hbr))) begin ec = 16; cf = 2'b11; end
        else if (!hv && empty && recov && |fe) begin
            if (fe[0]) begin ec = 6; cf[0] = 1; end
            else begin ec = 7; cf[1] = 1; end
        end else if (ee && recov && ((hv && hd) || (!hv && empty))) begin
            if (ae[3]) begin ec = 3; ca[3] = 1; end
            else if (ae[4]) begin ec = 4; ca[4] = 1; end
            else if (ae[5]) begin ec = 5; ca[5] = 1; end
        end
        ma = fl ? '0 : (ae & ~ca);
        mf = fl ? '0 : (fe & ~cf);
        mc = fl ? 1'b0 : (mc | st);
        @(posedge clk);
        #1;
        n_run++;
        if (take !== (ec >= 0) || cause !== ((ec >= 0) ? 5'(ec) : 5'd0) ||
            vec !== ((ec >= 0) ? exp_vec(ec) : 20'h0) || supp !== es ||
            cstop !== mc || hold !== (|mf)) begin
            n_fail++;
            $display("FAIL %s: take=%0b cause=%0d vec=%h supp=%0b stop=%0b hold=%0b exp take=%0b cause=%0d vec=%h supp=%0b stop=%0b hold=%0b",
                     (tag == "") ? req_of(ec) : tag, take, cause, vec, supp, cstop, hold,
                     ec >= 0, (ec >= 0) ? ec : 0, (ec >= 0) ? exp_vec(ec) : 20'h0,
                     es, mc, |mf);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        clr_in();
        ee = 0; me = 1; se = 0; be = 0; recov = 0; empty = 0;
        ma = '0; mf = '0; mc = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        // R1: idle after reset
        run_cycle("R1");
        // R2: hard reset wins over all others
        hres = 1; mchk = 1; sres = 1; ext = 1; recov = 1; run_cycle("R2"); clr_in();
        run_cycle("R2");
        // R3: machine check taken without recoverable state
        recov = 0; mchk = 1; run_cycle("R3"); clr_in();
        // R3: disabled check stops the machine; nothing else taken
        me = 0; mchk = 1; run_cycle("R3"); clr_in(); me = 1;
        ee = 1; recov = 1; empty = 1; ext = 1; run_cycle("R3"); clr_in();
        hv = 1; flt = 12'h001; run_cycle("R3"); clr_in();
        hres = 1; run_cycle("R3"); clr_in();
        // R4: soft reset waits for recoverable state
        recov = 0; sres = 1; run_cycle("R4"); clr_in();
        run_cycle("R4");
        recov = 1; run_cycle("R4");
        // R5: masked interrupts in rank order, gated by enable
        ee = 0; smi = 1; ext = 1; dec = 1; run_cycle("R5"); clr_in();
        run_cycle("R5");
        ee = 1; run_cycle("R5"); run_cycle("R5"); run_cycle("R5"); run_cycle("R5");
        // R6: fault taken, interrupt kept, then taken at completion
        empty = 0; ext = 1; hv = 1; flt = 12'h040; run_cycle("R6"); clr_in();
        hv = 1; hd = 1; run_cycle("R6"); clr_in();
        // R7: ranking and mapping
        hv = 1; flt = 12'h220; run_cycle("R7"); clr_in();
        hv = 1; flt = 12'h801; run_cycle("R7"); clr_in();
        hv = 1; flt = 12'h018; run_cycle("R7"); clr_in();
        hv = 1; flt = 12'h404; run_cycle("R7"); clr_in();
        // R8: translation miss by direction
        hv = 1; flt = 12'h100; hst = 1; run_cycle("R8"); clr_in();
        hv = 1; flt = 12'h100; run_cycle("R8"); clr_in();
        // R9: trace rules
        se = 1; hv = 1; hd = 1; run_cycle("R9"); clr_in(); se = 0;
        be = 1; hv = 1; hd = 1; run_cycle("R9"); clr_in();
        hv = 1; hd = 1; hbr = 1; run_cycle("R9"); clr_in();
        hv = 1; hd = 1; hbr = 1; flt = 12'h002; run_cycle("R9"); clr_in(); be = 0;
        // R10: fetch fault hold, discard, drain and take
        empty = 0; ftlb = 1; hv = 1; run_cycle("R10"); clr_in();
        hv = 1; flt = 12'h008; run_cycle("R10"); clr_in();
        facc = 1; ftlb = 1; run_cycle("R10"); clr_in();
        empty = 1; run_cycle("R10"); run_cycle("R10"); run_cycle("R10");
        // R11: everything at once, drained in class order
        recov = 0; empty = 0; ee = 1;
        mchk = 1; sres = 1; smi = 1; ftlb = 1; hv = 1; flt = 12'h010;
        run_cycle("R11"); clr_in();
        hv = 1; flt = 12'h010; run_cycle("R11"); clr_in();
        recov = 1; hv = 1; hd = 1; se = 1; run_cycle("R11"); clr_in(); se = 0;
        empty = 1; ftlb = 1; run_cycle("R11"); clr_in();
        run_cycle("R11"); run_cycle("R11");
        // constrained random mix
        for (int k = 0; k < 5000; k++) begin
            hres  = ($urandom_range(0, 199) == 0);
            mchk  = ($urandom_range(0, 59) == 0);
            me    = ($urandom_range(0, 9) != 0);
            sres  = ($urandom_range(0, 39) == 0);
            smi   = ($urandom_range(0, 19) == 0);
            ext   = ($urandom_range(0, 14) == 0);
            dec   = ($urandom_range(0, 19) == 0);
            ee    = ($urandom_range(0, 3) != 0);
            se    = ($urandom_range(0, 15) == 0);
            be    = ($urandom_range(0, 3) == 0);
            recov = ($urandom_range(0, 2) != 0);
            empty = ($urandom_range(0, 1) == 0);
            hv    = ($urandom_range(0, 1) == 0);
            hd    = ($urandom_range(0, 1) == 0);
            hbr   = ($urandom_range(0, 3) == 0);
            hst   = ($urandom_range(0, 1) == 0);
            flt   = ($urandom_range(0, 4) == 0) ? 12'($urandom) & 12'($urandom) : 12'h0;
            ftlb  = ($urandom_range(0, 29) == 0);
            facc  = ($urandom_range(0, 29) == 0);
            run_cycle("");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule